// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block runs one transmit queue that lives as a ring of descriptors in system memory. Software sets the memory location of the ring, its size in descriptors and a control word. It then posts work by moving a producer index (the head) past the descriptors it has filled in. The engine works through the descriptors one at a time. For each one it reads the 16-byte entry over a simple word-wide memory port and presents a frame request to the payload mover. When the mover accepts the request, the engine writes the entry back with its done flag set. It then moves its consumer index (the tail) forward.

Each descriptor is four 32-bit words. Word 0 holds the low half of the buffer address and word 1 the high half. Word 2 packs the length in bits 11:0, the end marker in bits 15:12, the start marker in bits 19:16 and a 12-bit flag field in bits 31:20. Word 3 is a time word that the engine clears. Within the flag field, value 0x2 (word bit 21) marks the entry as done, 0x4 (bit 22) marks it posted by software, and 0x8 (bit 23) asks for a completion event.

Software reaches the registers through a small write/read port with word addresses. Address 0 holds the low base address and address 1 the high base address. Address 2 holds the ring size. Address 3 is control, with bit 31 enabling the ring and bit 30 selecting raw mode. Address 4 holds the head, and address 5 returns the tail and is read-only.

Top module: `tx_ring_engine`

## Requirements
- R1: After reset the tail reads 0, and mem_req, frm_valid and done_evt are all low.
- R2: Descriptor i is fetched with three reads at base + 16*i + 0, +4 and +8, in that order. The base comes from registers 0 (low) and 1 (high).
- R3: The frame request carries the 64-bit buffer address from words 0 and 1 and the length from word 2 bits 11:0. It carries the end marker from bits 15:12 and the start marker from bits 19:16. All of these are held steady while frm_ready stays low, and the tail does not move during that time.
- R4: With control bit 30 set (raw mode), frm_raw is high and frm_sof and frm_eof are driven as zero.
- R5: After the frame handshake, the engine writes word 2 back with bit 21 set and every other bit unchanged, and then writes word 3 as zero.
- R6: done_evt pulses for exactly one cycle after a descriptor finishes, and only when bit 23 of its word 2 is set.
- R7: The tail advances by one when a descriptor finishes and wraps to 0 when it reaches the ring size. When tail equals head the ring is empty and no memory access is made.
- R8: A head write whose value is not below the ring size is ignored, and the head keeps its old value.
- R9: Clearing control bit 31 lets the descriptor in flight run to its writeback. After that the tail returns to 0 and no further fetches start, even while head differs from tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write word address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read word address |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access done |
| frm_valid | output | 1 | Frame request valid |
| frm_ready | input | 1 | Frame request accepted |
| frm_addr | output | 64 | Frame buffer address |
| frm_len | output | 12 | Frame length |
| frm_sof | output | 4 | Frame start marker |
| frm_eof | output | 4 | Frame end marker |
| frm_raw | output | 1 | Frame is sent in raw mode |
| done_evt | output | 1 | Completion event pulse |

## Verification
A register write takes effect at the next rising edge, and the read port reflects it within that same cycle. A fetch needs two edges per word with the bench's memory model. frm_valid rises on the edge that takes the third read word. The tail moves on the edge that acknowledges the time-word write, and done_evt is high for the cycle that follows. The bench therefore does not assume fixed counts through the memory path. It polls the tail and frm_valid at falling edges with bounded waits, and it samples the held frame fields only after frm_valid has been seen high. Events and memory accesses are counted at every edge, so that absent activity (an empty ring, a disabled ring, an event that must not fire) is checked over a fixed window.

// File: rtl/tre_pkg.sv
package tre_pkg;
  // register word addresses
  localparam logic [2:0] RA_BASE_LO = 3'd0;
  localparam logic [2:0] RA_BASE_HI = 3'd1;
  localparam logic [2:0] RA_SIZE    = 3'd2;
  localparam logic [2:0] RA_CTRL    = 3'd3;
  localparam logic [2:0] RA_HEAD    = 3'd4;
  localparam logic [2:0] RA_TAIL    = 3'd5;

  localparam int CTRL_EN_BIT  = 31;
  localparam int CTRL_RAW_BIT = 30;

  // descriptor word 2 fields
  localparam int LEN_LSB = 0;
  localparam int EOF_LSB = 12;
  localparam int SOF_LSB = 16;
  localparam int FLG_LSB = 20;
  localparam int DONE_BIT = FLG_LSB + 1;
  localparam int IRQ_BIT  = FLG_LSB + 3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_LO,
    S_RD_HI,
    S_RD_CTL,
    S_FRAME,
    S_WB_CTL,
    S_WB_TIME
  } tre_state_e;
endpackage

// File: rtl/tre_regs.sv
module tre_regs
  import tre_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_waddr,
  input  logic [31:0]      reg_wdata,
  input  logic [2:0]       reg_raddr,
  input  logic [IDX_W-1:0] tail,
  output logic [31:0]      reg_rdata,
  output logic [63:0]      base,
  output logic [IDX_W:0]   size,
  output logic             enable,
  output logic             raw,
  output logic [IDX_W-1:0] head
);
  localparam int PAD_S = 31 - IDX_W;
  localparam int PAD_I = 32 - IDX_W;

  logic [63:0]      base_q, base_n;
  logic [IDX_W:0]   size_q, size_n;
  logic             en_q, en_n, raw_q, raw_n;
  logic [IDX_W-1:0] head_q, head_n;
  logic [31:0]      size32;

  assign size32 = {{PAD_S{1'b0}}, size_q};

  always_comb begin
    base_n = base_q;
    size_n = size_q;
    en_n   = en_q;
    raw_n  = raw_q;
    head_n = head_q;
    if (reg_we) begin
      case (reg_waddr)
        RA_BASE_LO: base_n[31:0]  = reg_wdata;
        RA_BASE_HI: base_n[63:32] = reg_wdata;
        RA_SIZE:    size_n        = reg_wdata[IDX_W:0];
        RA_CTRL: begin
          en_n  = reg_wdata[CTRL_EN_BIT];
          raw_n = reg_wdata[CTRL_RAW_BIT];
        end
        RA_HEAD: if (reg_wdata < size32) head_n = reg_wdata[IDX_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
      en_q   <= 1'b0;
      raw_q  <= 1'b0;
      head_q <= '0;
    end else begin
      base_q <= base_n;
      size_q <= size_n;
      en_q   <= en_n;
      raw_q  <= raw_n;
      head_q <= head_n;
    end
  end

  always_comb begin
    case (reg_raddr)
      RA_BASE_LO: reg_rdata = base_q[31:0];
      RA_BASE_HI: reg_rdata = base_q[63:32];
      RA_SIZE:    reg_rdata = size32;
      RA_CTRL:    reg_rdata = {en_q, raw_q, 30'd0};
      RA_HEAD:    reg_rdata = {{PAD_I{1'b0}}, head_q};
      RA_TAIL:    reg_rdata = {{PAD_I{1'b0}}, tail};
      default:    reg_rdata = '0;
    endcase
  end

  assign base   = base_q;
  assign size   = size_q;
  assign enable = en_q;
  assign raw    = raw_q;
  assign head   = head_q;

  // an out-of-range head write leaves the head untouched
  assert_head_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_waddr == RA_HEAD && reg_wdata >= size32) |=> (head_q == $past(head_q)));
endmodule

// File: rtl/tre_addr.sv
module tre_addr #(
  parameter int IDX_W = 12
) (
  input  logic [63:0]      base,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       word,
  output logic [63:0]      addr
);
  localparam int PAD = 60 - IDX_W;

  logic [63:0] entry_off, word_off;

  assign entry_off = {{PAD{1'b0}}, idx, 4'b0000};
  assign word_off  = {60'd0, word, 2'b00};
  assign addr      = base + entry_off + word_off;
endmodule

// File: rtl/tre_seq.sv
module tre_seq
  import tre_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             raw,
  input  logic [IDX_W:0]   size,
  input  logic [IDX_W-1:0] head,
  output logic             mem_req,
  output logic             mem_we,
  output logic [1:0]       mem_word,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ack,
  output logic             frm_valid,
  input  logic             frm_ready,
  output logic [63:0]      frm_addr,
  output logic [11:0]      frm_len,
  output logic [3:0]       frm_sof,
  output logic [3:0]       frm_eof,
  output logic             frm_raw,
  output logic             done_evt,
  output logic [IDX_W-1:0] tail
);
  tre_state_e       state_q, state_n;
  logic [IDX_W-1:0] tail_q, tail_n, tail_wrap;
  logic [IDX_W:0]   tail_p1;
  logic [31:0]      lo_q, lo_n, hi_q, hi_n, ctl_q, ctl_n;
  logic             evt_q, evt_n;

  assign tail_p1   = {1'b0, tail_q} + 1'b1;
  assign tail_wrap = (tail_p1 >= size) ? '0 : tail_p1[IDX_W-1:0];

  always_comb begin
    state_n = state_q;
    tail_n  = tail_q;
    lo_n    = lo_q;
    hi_n    = hi_q;
    ctl_n   = ctl_q;
    evt_n   = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (!enable) tail_n = '0;
        else if (tail_q != head) state_n = S_RD_LO;
      end
      S_RD_LO: if (mem_ack) begin
        lo_n    = mem_rdata;
        state_n = S_RD_HI;
      end
      S_RD_HI: if (mem_ack) begin
        hi_n    = mem_rdata;
        state_n = S_RD_CTL;
      end
      S_RD_CTL: if (mem_ack) begin
        ctl_n   = mem_rdata;
        state_n = S_FRAME;
      end
      S_FRAME: if (frm_ready) state_n = S_WB_CTL;
      S_WB_CTL: if (mem_ack) state_n = S_WB_TIME;
      S_WB_TIME: if (mem_ack) begin
        tail_n  = tail_wrap;
        evt_n   = ctl_q[IRQ_BIT];
        state_n = S_IDLE;
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      tail_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      ctl_q   <= '0;
      evt_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      tail_q  <= tail_n;
      lo_q    <= lo_n;
      hi_q    <= hi_n;
      ctl_q   <= ctl_n;
      evt_q   <= evt_n;
    end
  end

  // memory side
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_word  = 2'd0;
    mem_wdata = '0;
    case (state_q)
      S_RD_LO:  mem_req = 1'b1;
      S_RD_HI: begin
        mem_req  = 1'b1;
        mem_word = 2'd1;
      end
      S_RD_CTL: begin
        mem_req  = 1'b1;
        mem_word = 2'd2;
      end
      S_WB_CTL: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_word  = 2'd2;
        mem_wdata = ctl_q | (32'd1 << DONE_BIT);
      end
      S_WB_TIME: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_word = 2'd3;
      end
      default: ;
    endcase
  end

  // frame side
  assign frm_valid = (state_q == S_FRAME);
  assign frm_addr  = {hi_q, lo_q};
  assign frm_len   = ctl_q[LEN_LSB +: 12];
  assign frm_sof   = raw ? 4'd0 : ctl_q[SOF_LSB +: 4];
  assign frm_eof   = raw ? 4'd0 : ctl_q[EOF_LSB +: 4];
  assign frm_raw   = raw;
  assign done_evt  = evt_q;
  assign tail      = tail_q;

  // R3: a waiting frame request keeps its contents
  assert_frame_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_ready) |=> (frm_valid && $stable(frm_addr) && $stable(frm_len)));
  // R3: no tail movement while the frame waits
  assert_tail_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_ready) |=> $stable(tail_q));
  // R5: the control word goes back with the done flag
  assert_done_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_word == 2'd2) |-> mem_wdata[DONE_BIT]);
  // R6: event is a single-cycle pulse
  assert_evt_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !done_evt);
  // R7: tail only steps by one or returns to zero
  assert_tail_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_q != $past(tail_q)) |-> (tail_q == '0 || tail_q == $past(tail_q) + 1'b1));
  // R2: a pending access holds its request until acknowledged
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_word) && $stable(mem_we)));
endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine #(
  parameter int IDX_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_waddr,
  input  logic [31:0] reg_wdata,
  input  logic [2:0]  reg_raddr,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [63:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic        frm_valid,
  input  logic        frm_ready,
  output logic [63:0] frm_addr,
  output logic [11:0] frm_len,
  output logic [3:0]  frm_sof,
  output logic [3:0]  frm_eof,
  output logic        frm_raw,
  output logic        done_evt
);
  logic [63:0]      base;
  logic [IDX_W:0]   size;
  logic             enable, raw;
  logic [IDX_W-1:0] head, tail;
  logic [1:0]       mem_word;

  tre_regs #(.IDX_W(IDX_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_waddr (reg_waddr),
    .reg_wdata (reg_wdata),
    .reg_raddr (reg_raddr),
    .tail      (tail),
    .reg_rdata (reg_rdata),
    .base      (base),
    .size      (size),
    .enable    (enable),
    .raw       (raw),
    .head      (head)
  );

  tre_seq #(.IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .raw       (raw),
    .size      (size),
    .head      (head),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_word  (mem_word),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack),
    .frm_valid (frm_valid),
    .frm_ready (frm_ready),
    .frm_addr  (frm_addr),
    .frm_len   (frm_len),
    .frm_sof   (frm_sof),
    .frm_eof   (frm_eof),
    .frm_raw   (frm_raw),
    .done_evt  (done_evt),
    .tail      (tail)
  );

  tre_addr #(.IDX_W(IDX_W)) u_addr (
    .base (base),
    .idx  (tail),
    .word (mem_word),
    .addr (mem_addr)
  );

  // R9: a disabled, idle ring makes no access
  assert_quiet_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !mem_req && !frm_valid) |=> !mem_req);
endmodule

// File: tb/test_tx_ring_engine.sv
module test_tx_ring_engine;
  localparam logic [63:0] BASE = 64'h0000_0001_0000_0200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [2:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        frm_valid, frm_ready, frm_raw, done_evt;
  logic [63:0] frm_addr;
  logic [11:0] frm_len;
  logic [3:0]  frm_sof, frm_eof;

  logic        ready_en = 1'b1;
  logic        ld_en = 1'b0;
  logic [4:0]  ld_idx = '0;
  logic [31:0] ld_data = '0;

  logic [31:0] mem [0:31];
  logic [63:0] rd_log [0:63];
  logic [63:0] fr_addr_log [0:15];
  logic [11:0] fr_len_log [0:15];
  int          rd_n = 0, acc_n = 0, fr_n = 0, evt_n = 0;
  int          total = 0, bad = 0;

  always #2 clk = ~clk;

  assign frm_ready = ready_en;

  tx_ring_engine i_tx_ring_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_addr(frm_addr),
    .frm_len(frm_len), .frm_sof(frm_sof), .frm_eof(frm_eof),
    .frm_raw(frm_raw), .done_evt(done_evt)
  );

  // memory model: one ack per request, a cycle after it is seen
  logic [4:0] widx;
  assign widx = 5'((mem_addr - BASE) >> 2);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      if (ld_en) mem[ld_idx] <= ld_data;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        acc_n   <= acc_n + 1;
        if (mem_we) mem[widx] <= mem_wdata;
        else begin
          mem_rdata <= mem[widx];
          rd_log[rd_n[5:0]] <= mem_addr;
          rd_n <= rd_n + 1;
        end
      end else mem_ack <= 1'b0;
      if (frm_valid && frm_ready) begin
        fr_addr_log[fr_n[3:0]] <= frm_addr;
        fr_len_log[fr_n[3:0]]  <= frm_len;
        fr_n <= fr_n + 1;
      end
      if (done_evt) evt_n <= evt_n + 1;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_raddr = a;
    #1 d = reg_rdata;
  endtask

  task automatic load(input int idx, input logic [31:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = 5'(idx); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic put_desc(input int i, input logic [31:0] lo, input logic [31:0] hi,
                          input logic [31:0] ctl);
    load(i*4, lo); load(i*4+1, hi); load(i*4+2, ctl); load(i*4+3, 32'hFFFF_FFFF);
  endtask

  task automatic wait_tail(input logic [31:0] t, input int frames);
    logic [31:0] v;
    for (int k = 0; k < 400; k++) begin
      reg_read(3'd5, v);
      if (v == t && fr_n == frames) break;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    reg_read(3'd5, v);
    check("R1 tail", v, 0);
    check("R1 mem_req", mem_req, 0);
    check("R1 frm_valid", frm_valid, 0);
    check("R1 done_evt", done_evt, 0);
  endtask

  task automatic t_single;
    put_desc(0, 32'hCAFE_0000, 32'h0000_0012, 32'h00C5_3040);
    reg_write(3'd4, 32'd1);
    wait_tail(1, 1);
    check("R2 rd0", rd_log[0], BASE);
    check("R2 rd1", rd_log[1], BASE + 4);
    check("R2 rd2", rd_log[2], BASE + 8);
    check("R3 addr", fr_addr_log[0], 64'h12_CAFE_0000);
    check("R3 len", fr_len_log[0], 12'h040);
    check("R5 word2", mem[2], 32'h00E5_3040);
    check("R5 word3", mem[3], 0);
    repeat (3) @(negedge clk);
    check("R6 evt irq", evt_n, 1);
  endtask

  task automatic t_noirq;
    put_desc(1, 32'h0000_8000, 32'h0, 32'h0041_2100);
    reg_write(3'd4, 32'd2);
    wait_tail(2, 2);
    repeat (3) @(negedge clk);
    check("R2 rd desc1", rd_log[3], BASE + 16);
    check("R3 addr desc1", fr_addr_log[1], 64'h8000);
    check("R5 word2 desc1", mem[6], 32'h0061_2100);
    check("R6 no evt", evt_n, 1);
  endtask

  task automatic t_wrap;
    put_desc(2, 32'h0000_1000, 32'h0, 32'h0080_0010);
    put_desc(3, 32'h0000_2000, 32'h0, 32'h0080_0020);
    reg_write(3'd4, 32'd0);
    wait_tail(0, 4);
    repeat (3) @(negedge clk);
    check("R7 frames", fr_n, 4);
    check("R7 order", fr_len_log[3], 12'h020);
    check("R7 evts", evt_n, 3);
  endtask

  task automatic t_range;
    logic [31:0] v;
    int a0;
    reg_write(3'd4, 32'd4);
    reg_read(3'd4, v);
    check("R8 head kept", v, 0);
    a0 = acc_n;
    repeat (20) @(negedge clk);
    check("R7 empty no access", acc_n, a0);
    reg_read(3'd5, v);
    check("R7 tail stays", v, 0);
  endtask

  task automatic t_raw_disable;
    logic [31:0] v;
    int a0;
    ready_en = 1'b0;
    reg_write(3'd3, 32'hC000_0000);
    put_desc(0, 32'hCAFE_0000, 32'h0000_0012, 32'h00C5_3040);
    reg_write(3'd4, 32'd1);
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (frm_valid) break;
    end
    repeat (10) @(negedge clk);
    check("R3 held valid", frm_valid, 1);
    check("R3 held len", frm_len, 12'h040);
    check("R4 raw flag", frm_raw, 1);
    check("R4 sof zero", frm_sof, 0);
    check("R4 eof zero", frm_eof, 0);
    reg_read(3'd5, v);
    check("R3 tail waits", v, 0);
    reg_write(3'd3, 32'h0);
    ready_en = 1'b1;
    repeat (30) @(negedge clk);
    check("R9 inflight done", mem[2], 32'h00E5_3040);
    check("R9 evt", evt_n, 4);
    reg_read(3'd5, v);
    check("R9 tail zero", v, 0);
    a0 = acc_n;
    reg_write(3'd4, 32'd3);
    repeat (20) @(negedge clk);
    check("R9 no fetch", acc_n, a0);
  endtask

  initial begin
    repeat (10) @(posedge clk);
    if (bad == 0 && total == 0) begin end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    reg_write(3'd0, BASE[31:0]);
    reg_write(3'd1, BASE[63:32]);
    reg_write(3'd2, 32'd4);
    reg_write(3'd3, 32'h8000_0000);
    t_single();
    t_noirq();
    t_wrap();
    t_range();
    t_raw_disable();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule